// File: doc/BRIEF.md
# Contiguous Ones Run Counter

This block counts the separate runs of consecutive ones in a data word (32 bits by default). A word is accepted when `start_i` is high while `ready_o` is high. The block then builds a boundary word that has a bit set at every place where adjacent bits of the input differ. A run that reaches the top bit has no upper boundary inside the word, so the boundary word is one bit wider than the input and that extra bit supplies the missing end.

Each busy cycle finds the two lowest set bits of the boundary word, using x AND (-x) twice, and clears them. These two bits are the start and end of one run, so each cycle removes a whole run and adds one to the count. The busy time therefore follows the number of runs and not the word width. When the boundary word is empty, `done_o` rises and the count appears on `count_o`. Both hold until the next word is accepted.

Top module: `run_counter`

## Requirements
- R1: After reset, `ready_o` is 1, `done_o` is 0 and `count_o` is 0.
- R2: A word is accepted on a rising clock edge where `start_i` and `ready_o` are both 1. From the next cycle on, `ready_o` and `done_o` are 0 and `count_o` restarts from 0.
- R3: When `done_o` rises, `count_o` equals the number of maximal runs of ones in the accepted word, as an unsigned binary value. For example, 0x711EC71F gives 6.
- R4: A run that includes the most significant bit is counted exactly once. For example, 0x80000000 gives 1, 0xFFFFFFFF gives 1 and 0x80000001 gives 2.
- R5: `done_o` rises max(1, runs) clock edges after the accepting edge.
- R6: An all-zero word finishes one edge after acceptance, with a count of 0.
- R7: The greatest count is half the word width. Both 0x55555555 and 0xAAAAAAAA give 16.
- R8: `ready_o` is 0 while the block is busy. A `start_i` pulse during that time is ignored, and the result of the running word is unchanged.
- R9: While no word is accepted, `done_o` stays 1 and `count_o` holds its value. `ready_o` is 1 in this state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to load `word_i` |
| word_i | input | DATA_W | Word to analyse |
| ready_o | output | 1 | Block can accept a word |
| done_o | output | 1 | Result valid and held |
| count_o | output | $clog2(DATA_W+1) | Number of runs of ones |

## Verification
The result of each word is due max(1, runs) edges after the edge that accepts it. The driver records the cycle number of that edge and pushes the expected count and latency into a scoreboard. The monitor samples on falling edges. It detects the rising edge of `done_o`, compares the count, and compares the measured cycle distance against the expected latency. Hold checks re-sample the outputs several idle cycles later. The ignored-start check pulses `start_i` one cycle after acceptance and then confirms that the original word's result is reported.

// File: rtl/run_cnt_pkg.sv
package run_cnt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } run_state_e;
endpackage

// File: rtl/edge_mark.sv
// Marks every 0/1 boundary; the top bit closes a run that touches the MSB.
module edge_mark #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W:0]   edge_o
);
  assign edge_o = {1'b0, word_i} ^ {word_i, 1'b0};
endmodule

// File: rtl/pair_strip.sv
// Clears the two lowest set bits (start and end of the lowest run).
module pair_strip #(
  parameter int unsigned TW = 33
) (
  input  logic [TW-1:0] edge_i,
  output logic [TW-1:0] edge_o,
  output logic          empty_o
);
  logic [TW-1:0] low_a, rest_a, low_b;

  always_comb begin
    low_a   = edge_i & (~edge_i + TW'(1));
    rest_a  = edge_i & ~low_a;
    low_b   = rest_a & (~rest_a + TW'(1));
    edge_o  = rest_a & ~low_b;
    empty_o = (edge_o == '0);
  end
endmodule

// File: rtl/run_counter.sv
module run_counter
  import run_cnt_pkg::*;
#(
  parameter  int unsigned DATA_W = 32,
  localparam int unsigned CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  count_o
);
  localparam int unsigned TW      = DATA_W + 1;
  localparam int unsigned MAX_RUN = DATA_W / 2;

  run_state_e    state_q;
  logic [TW-1:0] edge_q;
  logic [TW-1:0] edge_load;
  logic [TW-1:0] edge_next;
  logic          edge_empty;
  logic [CNT_W-1:0] cnt_q;

  edge_mark #(.DATA_W(DATA_W)) u_mark (
    .word_i (word_i),
    .edge_o (edge_load)
  );

  pair_strip #(.TW(TW)) u_strip (
    .edge_i  (edge_q),
    .edge_o  (edge_next),
    .empty_o (edge_empty)
  );

  assign ready_o = (state_q != ST_BUSY);
  assign done_o  = (state_q == ST_DONE);
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      edge_q  <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_BUSY: begin
          if (edge_q == '0) begin
            state_q <= ST_DONE;
          end else begin
            edge_q <= edge_next;
            cnt_q  <= cnt_q + CNT_W'(1);
            if (edge_empty) state_q <= ST_DONE;
          end
        end
        default: begin
          if (start_i) begin
            edge_q  <= edge_load;
            cnt_q   <= '0;
            state_q <= ST_BUSY;
          end
        end
      endcase
    end
  end

  // R2
  start_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && ready_o) |=> (!done_o && !ready_o && count_o == '0));

  // R4
  edge_parity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BUSY) |-> ($countones(edge_q) % 2 == 0));

  // R3
  one_run_per_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BUSY && edge_q != '0) |=> (count_o == $past(count_o) + CNT_W'(1)));

  // R7
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(MAX_RUN));

  // R9
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(count_o)));
endmodule

// File: tb/run_counter_tb_top.sv
module run_counter_tb_top;
  localparam int DATA_W = 32;
  localparam int CNT_W  = $clog2(DATA_W + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [DATA_W-1:0] word = '0;
  logic              ready, done;
  logic [CNT_W-1:0]  count;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int exp_cnt_q[$];
  int exp_lat_q[$];
  int acc_cyc_q[$];
  string tag_q[$];
  logic prev_done = 1'b0;

  run_counter #(.DATA_W(DATA_W)) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start), .word_i (word),
    .ready_o (ready), .done_o (done), .count_o (count)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int ref_runs(input logic [DATA_W-1:0] x);
    int n = 0;
    for (int i = 0; i < DATA_W; i++)
      if (x[i] && (i == 0 || !x[i-1])) n++;
    return n;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: scoreboard pop on rising done
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && !prev_done) begin
        if (exp_cnt_q.size() == 0) begin
          check("R3 unexpected done", 1, 0);
        end else begin
          automatic int ec = exp_cnt_q.pop_front();
          automatic int el = exp_lat_q.pop_front();
          automatic int ac = acc_cyc_q.pop_front();
          automatic string t = tag_q.pop_front();
          check({t, " count"}, int'(count), ec);
          check("R5 latency", cyc - ac, el);
        end
      end
      prev_done <= done;
    end
  end

  // Driver: accept one word, push expectation, optionally poke start while busy
  task automatic drive(input logic [DATA_W-1:0] x, input string t, input bit poke);
    int r;
    while (!ready) @(negedge clk);
    r = ref_runs(x);
    start = 1'b1;
    word  = x;
    @(negedge clk);
    exp_cnt_q.push_back(r);
    exp_lat_q.push_back(r > 1 ? r : 1);
    acc_cyc_q.push_back(cyc);
    tag_q.push_back(t);
    start = 1'b0;
    word  = '0;
    check("R2 ready low after accept", int'(ready), 0);
    check("R2 done low after accept", int'(done), 0);
    if (poke) begin
      // R8: start while busy must be ignored
      start = 1'b1;
      word  = 32'h0000_0000;
      @(negedge clk);
      start = 1'b0;
    end
    while (exp_cnt_q.size() != 0) @(negedge clk);
  endtask

  task automatic hold_check();
    int c = int'(count);
    repeat (4) @(negedge clk);
    check("R9 done held", int'(done), 1);
    check("R9 ready while done", int'(ready), 1);
    check("R9 count held", int'(count), c);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL R5 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] lfsr = 32'hACE1_2469;
    repeat (3) @(negedge clk);
    // R1
    check("R1 ready", int'(ready), 1);
    check("R1 done", int'(done), 0);
    check("R1 count", int'(count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after release", int'(ready), 1);

    drive(32'h711E_C71F, "R3", 1'b0);
    check("R3 sample word", int'(count), 6);
    hold_check();
    drive(32'h0000_0000, "R6", 1'b0);
    drive(32'h8000_0000, "R4", 1'b0);
    drive(32'hFFFF_FFFF, "R4", 1'b0);
    drive(32'h8000_0001, "R4", 1'b0);
    drive(32'hF000_000F, "R4", 1'b0);
    drive(32'h0000_0001, "R3", 1'b0);
    drive(32'h5555_5555, "R7", 1'b0);
    hold_check();
    drive(32'hAAAA_AAAA, "R7", 1'b0);
    drive(32'h5A5A_F00F, "R8", 1'b1);
    hold_check();
    for (int k = 0; k < 24; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      drive(lfsr, "R3", k[0]);
    end
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule